// File: doc/BRIEF.md
# Connection Memory Block-Fill Controller

This block loads a fixed pattern into every word of two connection memories, one for the backplane side and one for the local side, as a single background operation. Software holds a small control register with a start bit and two 3-bit pattern fields, one per memory. A separate global input grants permission for block programming. When permission is present and software moves the start bit from 0 to 1, the controller walks every address once. It writes to both memories in parallel, one word per clock. Each word carries its memory's pattern in the three most significant bits and zeros in all lower bits.

When the last address has been written, the controller clears the start bit by itself and raises a one-cycle done pulse. Software can stop a fill early by writing the start bit back to 0. Words already written keep the pattern, and no word is written after the cycle in which the abort arrives. The memories are plain synchronous RAMs outside this block. The controller drives a shared write enable, a shared address and one data word for each memory.

Top module: `cm_fill_ctrl`

## Requirements
- R1: After reset the start bit and both pattern fields read 0, and `busy`, `done` and `mem_we` are low.
- R2: A fill begins only on a register write that changes the start bit from 0 to 1 while `glob_en` is high. `busy` is high, with `mem_addr` = 0, in the cycle after that write. Writing 1 to a start bit that already reads 1 begins nothing.
- R3: A 0-to-1 write of the start bit while `glob_en` is low stores the bit but produces no memory write, and `busy` stays low.
- R4: Every backplane word written has the backplane pattern in bits 15-13 and zeros in bits 12-0.
- R5: Every local word written has the local pattern in bits 15-13 and zeros in bits 12-0, independently of the backplane pattern.
- R6: During a fill, `mem_we` is high every cycle. `mem_addr` steps by one from 0 to DEPTH-1, the same address for both memories, for exactly DEPTH writes.
- R7: In the cycle after the write to address DEPTH-1, `busy` is low, the start bit reads 0 and `done` is high for exactly one cycle.
- R8: A register write with start = 0 during a fill aborts it. The word at the current address is still written, then no further writes occur. Earlier words keep the pattern, later words are untouched, `done` is not raised and the start bit reads 0.
- R9: Writing the start bit as 1 again during a fill does not restart it. The fill still makes exactly DEPTH writes.
- R10: The patterns are captured when a fill begins. Pattern-field writes during the fill appear in the register readback but not in the words of that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| glob_en | input | 1 | Global block-programming permission |
| reg_we | input | 1 | Control register write strobe |
| wr_start | input | 1 | Start bit value written |
| wr_bk_pat | input | 3 | Backplane pattern field value written |
| wr_lc_pat | input | 3 | Local pattern field value written |
| start_q | output | 1 | Start bit readback |
| bk_pat_q | output | 3 | Backplane pattern readback |
| lc_pat_q | output | 3 | Local pattern readback |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| mem_we | output | 1 | Write enable to both memories |
| mem_addr | output | log2(DEPTH) | Write address shared by both memories |
| bk_wdata | output | 16 | Backplane memory write data |
| lc_wdata | output | 16 | Local memory write data |

## Verification
Full fills are run from a table of pattern pairs with different values on the two sides, such as 5/2, 0/7 and 7/0. These pairs show whether the two fields are swapped or mixed, and whether any pattern bit is stuck. Before each fill both memories are preset to all ones, so any lower bit left set, or any word skipped, is visible in the final contents. Directed runs then test the launch conditions: permission low, a repeated 1 with no edge, and a mid-fill rewrite of the start bit together with new patterns. A final run aborts at a known address and checks the boundary between written and untouched words.

// File: rtl/cmf_pkg.sv
package cmf_pkg;
  localparam int CMF_PAT_W  = 3;
  localparam int CMF_WORD_W = 16;
  localparam int CMF_N_MEM  = 2;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/cmf_ctl_regs.sv
module cmf_ctl_regs #(
  parameter int PAT_W = cmf_pkg::CMF_PAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             wr_start,
  input  logic [PAT_W-1:0] wr_bk_pat,
  input  logic [PAT_W-1:0] wr_lc_pat,
  input  logic             hw_clear,
  output logic             start_q,
  output logic [PAT_W-1:0] bk_pat_q,
  output logic [PAT_W-1:0] lc_pat_q,
  output logic             start_rise,
  output logic             start_drop
);
  logic             start_d;
  logic [PAT_W-1:0] bk_d;
  logic [PAT_W-1:0] lc_d;

  // Software write first, completion clear overrides it.
  always_comb begin
    start_d = start_q;
    bk_d    = bk_pat_q;
    lc_d    = lc_pat_q;
    if (reg_we) begin
      start_d = wr_start;
      bk_d    = wr_bk_pat;
      lc_d    = wr_lc_pat;
    end
    if (hw_clear) begin
      start_d = 1'b0;
    end
  end

  assign start_rise = reg_we &  wr_start & ~start_q;
  assign start_drop = reg_we & ~wr_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      bk_pat_q <= '0;
      lc_pat_q <= '0;
    end else begin
      start_q  <= start_d;
      bk_pat_q <= bk_d;
      lc_pat_q <= lc_d;
    end
  end
endmodule

// File: rtl/cmf_fill_seq.sv
module cmf_fill_seq #(
  parameter int DEPTH = 4096,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          abort,
  output logic          busy,
  output logic          done,
  output logic          complete,
  output logic          capture,
  output logic [AW-1:0] addr
);
  import cmf_pkg::*;

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  fill_state_e   state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;
  logic          addr_en;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    addr_en  = 1'b0;
    done_d   = 1'b0;
    complete = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        if (launch) begin
          state_d = FS_FILL;
          addr_d  = '0;
          addr_en = 1'b1;
          capture = 1'b1;
        end
      end
      FS_FILL: begin
        if (abort) begin
          state_d = FS_IDLE;
        end else if (addr_q == LAST) begin
          state_d  = FS_IDLE;
          done_d   = 1'b1;
          complete = 1'b1;
        end else begin
          addr_d  = addr_q + 1'b1;
          addr_en = 1'b1;
        end
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign busy = (state_q == FS_FILL);
  assign done = done_q;
  assign addr = addr_q;
endmodule

// File: rtl/cmf_word_fmt.sv
module cmf_word_fmt #(
  parameter int WORD_W = cmf_pkg::CMF_WORD_W,
  parameter int PAT_W  = cmf_pkg::CMF_PAT_W,
  parameter int N_MEM  = cmf_pkg::CMF_N_MEM,
  localparam int LOW_W = WORD_W - PAT_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          capture,
  input  logic [N_MEM-1:0][PAT_W-1:0]   pat_in,
  output logic [N_MEM-1:0][WORD_W-1:0]  word_out
);
  for (genvar m = 0; m < N_MEM; m++) begin : g_mem
    logic [PAT_W-1:0] pat_hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pat_hold_q <= '0;
      end else if (capture) begin
        pat_hold_q <= pat_in[m];
      end
    end

    assign word_out[m] = {pat_hold_q, {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/cm_fill_ctrl.sv
module cm_fill_ctrl #(
  parameter int DEPTH  = 4096,
  parameter int WORD_W = cmf_pkg::CMF_WORD_W,
  parameter int PAT_W  = cmf_pkg::CMF_PAT_W,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              glob_en,
  input  logic              reg_we,
  input  logic              wr_start,
  input  logic [PAT_W-1:0]  wr_bk_pat,
  input  logic [PAT_W-1:0]  wr_lc_pat,
  output logic              start_q,
  output logic [PAT_W-1:0]  bk_pat_q,
  output logic [PAT_W-1:0]  lc_pat_q,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] bk_wdata,
  output logic [WORD_W-1:0] lc_wdata
);
  localparam int N_MEM = 2;

  logic start_rise, start_drop;
  logic complete, capture;
  logic [N_MEM-1:0][PAT_W-1:0]  pats;
  logic [N_MEM-1:0][WORD_W-1:0] words;

  cmf_ctl_regs #(.PAT_W(PAT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .wr_start   (wr_start),
    .wr_bk_pat  (wr_bk_pat),
    .wr_lc_pat  (wr_lc_pat),
    .hw_clear   (complete),
    .start_q    (start_q),
    .bk_pat_q   (bk_pat_q),
    .lc_pat_q   (lc_pat_q),
    .start_rise (start_rise),
    .start_drop (start_drop)
  );

  cmf_fill_seq #(.DEPTH(DEPTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (start_rise & glob_en),
    .abort    (start_drop),
    .busy     (busy),
    .done     (done),
    .complete (complete),
    .capture  (capture),
    .addr     (mem_addr)
  );

  // Patterns come from the write data when it carries the rising start bit.
  assign pats[0] = wr_bk_pat;
  assign pats[1] = wr_lc_pat;

  cmf_word_fmt #(.WORD_W(WORD_W), .PAT_W(PAT_W), .N_MEM(N_MEM)) u_fmt (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (capture),
    .pat_in   (pats),
    .word_out (words)
  );

  assign mem_we   = busy;
  assign bk_wdata = words[0];
  assign lc_wdata = words[1];
endmodule

// File: rtl/cm_fill_ctrl_chk.sv
module cm_fill_ctrl_chk #(
  parameter int AW     = 12,
  parameter int WORD_W = 16,
  parameter int PAT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_en,
  input logic              start_q,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [WORD_W-1:0] bk_wdata,
  input logic [WORD_W-1:0] lc_wdata
);
  localparam int LOW_W = WORD_W - PAT_W;

  // R2: a fill only starts with permission present
  p_launch_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(glob_en) && mem_addr == '0));

  // R3: no write without an active fill
  p_no_write_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  // R4: backplane lower bits are zero
  p_bk_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (bk_wdata[LOW_W-1:0] == '0));

  // R5: local lower bits are zero
  p_lc_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (lc_wdata[LOW_W-1:0] == '0));

  // R6: the address advances by one each cycle of a fill
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  // R7: done is a single-cycle pulse with the start bit cleared
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!start_q && !busy && $past(busy)));

  // R8: any end of a fill leaves the start bit low
  p_end_clears_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !start_q);
endmodule

bind cm_fill_ctrl cm_fill_ctrl_chk #(
  .AW(AW), .WORD_W(WORD_W), .PAT_W(PAT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .glob_en  (glob_en),
  .start_q  (start_q),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .bk_wdata (bk_wdata),
  .lc_wdata (lc_wdata)
);

// File: tb/test_cm_fill_ctrl.sv
`timescale 1ns/1ps
module test_cm_fill_ctrl;
  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);
  localparam int NVEC  = 4;
  // each entry: {backplane pattern, local pattern}
  localparam logic [5:0] VEC [NVEC] = '{6'b101_010, 6'b111_000, 6'b000_111, 6'b011_110};

  logic clk = 1'b0;
  logic rst_n, glob_en, reg_we, wr_start;
  logic [2:0] wr_bk_pat, wr_lc_pat, bk_pat_q, lc_pat_q;
  logic start_q, busy, done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0] bk_wdata, lc_wdata;

  logic [15:0] bmem [DEPTH];
  logic [15:0] lmem [DEPTH];
  int wr_cnt, exp_addr, addr_err, done_seen;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cm_fill_ctrl #(.DEPTH(DEPTH)) i_cm_fill_ctrl (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .reg_we(reg_we),
    .wr_start(wr_start), .wr_bk_pat(wr_bk_pat), .wr_lc_pat(wr_lc_pat),
    .start_q(start_q), .bk_pat_q(bk_pat_q), .lc_pat_q(lc_pat_q),
    .busy(busy), .done(done), .mem_we(mem_we), .mem_addr(mem_addr),
    .bk_wdata(bk_wdata), .lc_wdata(lc_wdata)
  );

  always @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr] <= bk_wdata;
      lmem[mem_addr] <= lc_wdata;
      if (int'(mem_addr) != exp_addr) addr_err = addr_err + 1;
      exp_addr = exp_addr + 1;
      wr_cnt   = wr_cnt + 1;
    end
    if (done) done_seen = done_seen + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic prep();
    for (int i = 0; i < DEPTH; i++) begin
      bmem[i] = 16'hFFFF;
      lmem[i] = 16'hFFFF;
    end
    wr_cnt = 0; exp_addr = 0; addr_err = 0; done_seen = 0;
  endtask

  task automatic wreg(input logic s, input logic [2:0] b, input logic [2:0] l);
    reg_we = 1'b1; wr_start = s; wr_bk_pat = b; wr_lc_pat = l;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < DEPTH + 8 && busy; i++) @(negedge clk);
  endtask

  function automatic int mem_mismatch(input logic [2:0] b, input logic [2:0] l);
    int n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (bmem[i] != {b, 13'h0}) n++;
      if (lmem[i] != {l, 13'h0}) n++;
    end
    return n;
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5 * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    rst_n = 1'b0; glob_en = 1'b0; reg_we = 1'b0; wr_start = 1'b0;
    wr_bk_pat = '0; wr_lc_pat = '0;
    prep();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!start_q && bk_pat_q == 0 && lc_pat_q == 0, "R1 regs", {start_q, bk_pat_q, lc_pat_q}, 0);
    chk(!busy && !done && !mem_we, "R1 ctl", {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    glob_en = 1'b1;

    // table of full fills: R2, R4, R5, R6, R7
    for (int v = 0; v < NVEC; v++) begin
      prep();
      wreg(1'b1, VEC[v][5:3], VEC[v][2:0]);
      chk(busy && mem_addr == 0, "R2 launch", {busy, mem_addr}, 'h100);
      wait_idle();
      chk(done && !busy && !start_q, "R7 completion", {done, busy, start_q}, 'h4);
      @(negedge clk);
      chk(!done && done_seen == 1, "R7 done pulse", done_seen, 1);
      chk(wr_cnt == DEPTH && addr_err == 0, "R6 write count/order", wr_cnt, DEPTH);
      chk(mem_mismatch(VEC[v][5:3], VEC[v][2:0]) == 0, "R4 R5 words",
          mem_mismatch(VEC[v][5:3], VEC[v][2:0]), 0);
    end

    // R3: permission low, rising start bit stores but does not fill
    glob_en = 1'b0;
    prep();
    wreg(1'b1, 3'd6, 3'd1);
    repeat (4) @(negedge clk);
    chk(!busy && wr_cnt == 0 && start_q, "R3 no fill without permission", wr_cnt, 0);
    // R2: writing 1 again with no edge does not launch
    glob_en = 1'b1;
    wreg(1'b1, 3'd6, 3'd1);
    repeat (4) @(negedge clk);
    chk(!busy && wr_cnt == 0, "R2 no edge no fill", wr_cnt, 0);
    wreg(1'b0, 3'd6, 3'd1);

    // R9 + R10: rewrite start=1 with new patterns mid-fill
    prep();
    wreg(1'b1, 3'd2, 3'd5);
    repeat (20) @(negedge clk);
    wreg(1'b1, 3'd7, 3'd7);
    chk(bk_pat_q == 3'd7 && lc_pat_q == 3'd7, "R10 readback updates", {bk_pat_q, lc_pat_q}, 'o77);
    wait_idle();
    @(negedge clk);
    chk(wr_cnt == DEPTH && addr_err == 0, "R9 no restart", wr_cnt, DEPTH);
    chk(mem_mismatch(3'd2, 3'd5) == 0, "R10 captured patterns", mem_mismatch(3'd2, 3'd5), 0);

    // R8: abort at address 10
    prep();
    wreg(1'b1, 3'd4, 3'd3);
    repeat (10) @(negedge clk);
    chk(mem_addr == 10, "R8 abort point", mem_addr, 10);
    wreg(1'b0, 3'd4, 3'd3);
    repeat (3) @(negedge clk);
    chk(!busy && !start_q && done_seen == 0, "R8 stopped no done", {busy, start_q, done_seen}, 0);
    chk(wr_cnt == 11, "R8 write count", wr_cnt, 11);
    chk(bmem[10] == 16'h8000 && lmem[10] == 16'h6000, "R8 last word written", bmem[10], 'h8000);
    chk(bmem[0] == 16'h8000 && lmem[0] == 16'h6000, "R8 first word kept", lmem[0], 'h6000);
    chk(bmem[11] == 16'hFFFF && lmem[DEPTH-1] == 16'hFFFF, "R8 later untouched", bmem[11], 'hFFFF);

    summary();
  end
endmodule